// File: doc/BRIEF.md
# Vectored Two-Source Interrupt Controller

This block sits between two peripheral interrupt request lines and the instruction fetch unit of a small processor core. Each clock cycle it decides whether a pending request may interrupt the program that is running. A request needs three things to be taken: it must be asserted, it must be unmasked, and it must outrank whatever handler is already active. When a request is taken, the block sends a one-cycle take pulse and a code address to the fetch unit. The handler for source 0 starts at 0003h and the handler for source 1 starts at 000Bh. In the same cycle the block sends a one-cycle clear pulse back to the peripheral that raised the request. Saving and restoring the processor context is the job of the core.

Each source has one priority bit. The block keeps one in-service flag for the low level and one for the high level. This allows one level of nesting: a high-priority source may interrupt a low-priority handler, and nothing may interrupt a high-priority handler. When the core executes its return instruction, it pulses a return strobe. The strobe clears the highest in-service flag that is set, so requests at that level can be taken again.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset `take_stb`, `req_clr` and `take_vec` are all zero and neither in-service level is active, so the first enabled request is taken.
- R2: A request is taken only while `irq_glob_en` and that source's bit of `irq_src_en` are both 1; a masked request stays pending and is taken once it is unmasked.
- R3: The vector that goes with a take is 0003h for source 0 and 000Bh for source 1 (8-byte slots after the reset vector); `take_vec` is zero when no take is signalled.
- R4: A take appears one clock after the qualifying inputs, as a one-cycle `take_stb` together with `req_clr` having only bit i set, where i is the taken source.
- R5: When sources of different priority request together, the source whose `irq_src_hi` bit is 1 (high) is taken first, whatever its index.
- R6: When both sources request at the same priority, source 0 is taken first.
- R7: While only a low-priority handler is in service, a high-priority request is taken (nesting), and a low-priority request is not.
- R8: While a high-priority handler is in service, no request is taken.
- R9: A `reti_stb` pulse clears the high in-service level if it is active, and otherwise clears the low level. With both levels active, one return still blocks low-priority requests, and a second return allows them.
- R10: A `reti_stb` pulse with no handler in service changes no output and does not affect later takes.
- R11: A request that stays asserted after its take is not taken again until a return clears its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Request level from each peripheral |
| irq_glob_en | input | 1 | Global interrupt enable |
| irq_src_en | input | NUM_SRC | Per-source enable |
| irq_src_hi | input | NUM_SRC | Per-source priority, 1 = high |
| reti_stb | input | 1 | Return-from-handler strobe from the core |
| take_stb | output | 1 | One-cycle pulse: redirect fetch to `take_vec` |
| take_vec | output | ADDR_W | Handler address of the taken source |
| req_clr | output | NUM_SRC | One-cycle clear pulse to the taken source |

## Verification
The bench targets four areas:
- **Simultaneous requests.** It raises both requests in the same cycle at equal and at unequal priority. A wrong tie-break or priority compare would take the wrong source first.
- **Nesting at each level.** It checks that a low request cannot interrupt a low handler while a high request can, and that a high handler blocks everything. A controller that compares with "greater or equal" would re-enter the same level.
- **Returns.** It issues returns with both levels active, one level active and none active. If the return cleared the wrong in-service flag, a blocked low request would leak through early.
- **Persistent request.** A request held high after its clear pulse must be taken exactly once more, and only after the return. A controller that forgets its in-service state would take it again on every cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   typedef enum logic [0:0] {
      PRIO_LOW  = 1'b0,
      PRIO_HIGH = 1'b1
   } prio_e;

   // in-service state: bit 0 = low level active, bit 1 = high level active
   localparam int unsigned SVC_W = 2;

   // A return clears the top active level first; a take then marks its level.
   function automatic logic [SVC_W-1:0] svc_next(
      input logic [SVC_W-1:0] cur,
      input logic             ret,
      input logic             take,
      input prio_e            lvl
   );
      logic [SVC_W-1:0] nxt;
      nxt = cur;
      if (ret) begin
         if (nxt[1]) nxt[1] = 1'b0;
         else        nxt[0] = 1'b0;
      end
      if (take) begin
         if (lvl == PRIO_HIGH) nxt[1] = 1'b1;
         else                  nxt[0] = 1'b1;
      end
      return nxt;
   endfunction

endpackage

// File: rtl/irq_vec_qualify.sv
module irq_vec_qualify #(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] hi,
   input  logic               glob,
   input  logic               svc_lo,
   input  logic               svc_hi,
   output logic [NUM_SRC-1:0] elig
);

   // high sources are only shut out by a high handler; low ones by any handler
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic level_ok;
      assign level_ok = hi[g] ? ~svc_hi : ~(svc_hi | svc_lo);
      assign elig[g]  = glob & en[g] & req[g] & level_ok;
   end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC       = 2,
   parameter int TIE_LOW_FIRST = 1,
   parameter int IDX_W         = 1
) (
   input  logic [NUM_SRC-1:0] elig,
   input  logic [NUM_SRC-1:0] hi,
   output logic               found,
   output logic [IDX_W-1:0]   idx,
   output prio_e              prio
);

   // Scan in tie-break order; a later candidate wins only with strictly higher priority.
   if (TIE_LOW_FIRST != 0) begin : g_low_first
      always_comb begin
         found = 1'b0;
         idx   = '0;
         prio  = PRIO_LOW;
         for (int k = 0; k < NUM_SRC; k++) begin
            if (elig[k] && (!found || (hi[k] && prio == PRIO_LOW))) begin
               found = 1'b1;
               idx   = IDX_W'(k);
               prio  = hi[k] ? PRIO_HIGH : PRIO_LOW;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         found = 1'b0;
         idx   = '0;
         prio  = PRIO_LOW;
         for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (elig[k] && (!found || (hi[k] && prio == PRIO_LOW))) begin
               found = 1'b1;
               idx   = IDX_W'(k);
               prio  = hi[k] ? PRIO_HIGH : PRIO_LOW;
            end
         end
      end
   end

endmodule

// File: rtl/irq_vec_svc.sv
module irq_vec_svc
   import irq_vec_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ret,
   input  logic  take,
   input  prio_e take_prio,
   output logic  svc_lo,
   output logic  svc_hi
);

   logic [SVC_W-1:0] svc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_q <= '0;
      else        svc_q <= svc_next(svc_q, ret, take, take_prio);
   end

   assign svc_lo = svc_q[0];
   assign svc_hi = svc_q[1];

endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
   import irq_vec_pkg::*;
#(
   parameter int NUM_SRC       = 2,
   parameter int ADDR_W        = 16,
   parameter int VEC_BASE      = 3,
   parameter int SLOT_BYTES    = 8,
   parameter int TIE_LOW_FIRST = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               irq_glob_en,
   input  logic [NUM_SRC-1:0] irq_src_en,
   input  logic [NUM_SRC-1:0] irq_src_hi,
   input  logic               reti_stb,
   output logic               take_stb,
   output logic [ADDR_W-1:0]  take_vec,
   output logic [NUM_SRC-1:0] req_clr
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1 || NUM_SRC > 16) begin : g_bad_num
      $error("irq_vec_ctl: NUM_SRC must lie in 1..16");
   end
   if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_addr
      $error("irq_vec_ctl: ADDR_W must lie in 4..30");
   end
   if (SLOT_BYTES < 1 || VEC_BASE < 0) begin : g_bad_slot
      $error("irq_vec_ctl: SLOT_BYTES must be positive and VEC_BASE non-negative");
   end
   if (VEC_BASE + NUM_SRC * SLOT_BYTES > (1 << ADDR_W)) begin : g_bad_fit
      $error("irq_vec_ctl: vector slots exceed the address space");
   end

   logic [NUM_SRC-1:0] elig;
   logic               found;
   logic [IDX_W-1:0]   sel_idx;
   prio_e              sel_prio;
   logic               svc_lo;
   logic               svc_hi;
   logic [ADDR_W-1:0]  vec_calc;
   logic [NUM_SRC-1:0] clr_calc;

   irq_vec_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
      .req    (irq_req),
      .en     (irq_src_en),
      .hi     (irq_src_hi),
      .glob   (irq_glob_en),
      .svc_lo (svc_lo),
      .svc_hi (svc_hi),
      .elig   (elig)
   );

   irq_vec_arbiter #(
      .NUM_SRC       (NUM_SRC),
      .TIE_LOW_FIRST (TIE_LOW_FIRST),
      .IDX_W         (IDX_W)
   ) u_arb (
      .elig  (elig),
      .hi    (irq_src_hi),
      .found (found),
      .idx   (sel_idx),
      .prio  (sel_prio)
   );

   irq_vec_svc u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .ret       (reti_stb),
      .take      (found),
      .take_prio (sel_prio),
      .svc_lo    (svc_lo),
      .svc_hi    (svc_hi)
   );

   assign vec_calc = ADDR_W'(VEC_BASE) + ADDR_W'(sel_idx) * ADDR_W'(SLOT_BYTES);
   assign clr_calc = NUM_SRC'(1) << sel_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_stb <= 1'b0;
         take_vec <= '0;
         req_clr  <= '0;
      end else begin
         take_stb <= found;
         take_vec <= found ? vec_calc : '0;
         req_clr  <= found ? clr_calc : '0;
      end
   end

endmodule

// File: rtl/irq_vec_ctl_chk.sv
module irq_vec_ctl_chk #(
   parameter int NUM_SRC    = 2,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 3,
   parameter int SLOT_BYTES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_req,
   input logic               irq_glob_en,
   input logic               take_stb,
   input logic [ADDR_W-1:0]  take_vec,
   input logic [NUM_SRC-1:0] req_clr,
   input logic               svc_hi
);

   function automatic logic [ADDR_W-1:0] slot_of(input logic [NUM_SRC-1:0] m);
      logic [ADDR_W-1:0] a;
      a = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (m[i]) a = ADDR_W'(VEC_BASE + i * SLOT_BYTES);
      return a;
   endfunction

   AST_NO_TAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_glob_en |=> !take_stb); // R2

   AST_CLR_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      take_stb |-> ((req_clr & $past(irq_req)) != '0)); // R2

   AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      take_stb |-> (take_vec == slot_of(req_clr))); // R3

   AST_ONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      take_stb |-> ($countones(req_clr) == 1)); // R4

   AST_HIGH_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      svc_hi |=> !take_stb); // R8

   AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      take_stb |=> !(take_stb && req_clr == $past(req_clr))); // R11

endmodule

bind irq_vec_ctl irq_vec_ctl_chk #(
   .NUM_SRC    (NUM_SRC),
   .ADDR_W     (ADDR_W),
   .VEC_BASE   (VEC_BASE),
   .SLOT_BYTES (SLOT_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_req     (irq_req),
   .irq_glob_en (irq_glob_en),
   .take_stb    (take_stb),
   .take_vec    (take_vec),
   .req_clr     (req_clr),
   .svc_hi      (svc_hi)
);

// File: tb/test_irq_vec_ctl.sv
`timescale 1ns/1ps
module test_irq_vec_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req_q = '0;
   logic [1:0]  en_q = '0;
   logic [1:0]  hi_q = '0;
   logic        glob_q = 1'b0;
   logic        reti_q = 1'b0;
   logic        take_stb;
   logic [15:0] take_vec;
   logic [1:0]  req_clr;

   typedef struct {
      int    idx;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   auto_clr = 1'b1;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   irq_vec_ctl i_irq_vec_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_req     (req_q),
      .irq_glob_en (glob_q),
      .irq_src_en  (en_q),
      .irq_src_hi  (hi_q),
      .reti_stb    (reti_q),
      .take_stb    (take_stb),
      .take_vec    (take_vec),
      .req_clr     (req_clr)
   );

   // monitor: sample 2 ns after each rising edge, compare against the scoreboard
   always @(posedge clk) begin
      #2;
      if (rst_n && take_stb) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected take (R2/R7/R8/R11): vec=%h clr=%b expected no take",
                     take_vec, req_clr);
         end else begin
            exp_t        e;
            logic [15:0] ev;
            logic [1:0]  ec;
            e  = exp_q.pop_front();
            ev = 16'(3 + 8 * e.idx);
            ec = 2'(1 << e.idx);
            if (take_vec !== ev || req_clr !== ec) begin
               n_bad++;
               $display("FAIL %s (R3/R4): vec=%h clr=%b expected vec=%h clr=%b",
                        e.tag, take_vec, req_clr, ev, ec);
            end
         end
         if (auto_clr) req_q = req_q & ~req_clr;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_take(input int idx, input string tag);
      exp_t e;
      e.idx = idx;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic settle(input string tag);
      cyc(4);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL %s: %0d expected takes missing, expected 0", tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   task automatic reti_pulse();
      reti_q = 1'b1;
      cyc(1);
      reti_q = 1'b0;
   endtask

   task automatic check_idle(input string tag);
      n_chk++;
      if (take_stb !== 1'b0 || req_clr !== 2'b00 || take_vec !== 16'h0000) begin
         n_bad++;
         $display("FAIL %s: take=%b clr=%b vec=%h expected take=0 clr=00 vec=0000",
                  tag, take_stb, req_clr, take_vec);
      end
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      cyc(2);
      check_idle("R1 after reset");

      // R1 / R3: a fresh controller takes each source at its own slot
      glob_q = 1'b1; en_q = 2'b11; hi_q = 2'b00;
      expect_take(0, "R1");
      req_q[0] = 1'b1;
      settle("R1");
      check_idle("R3 idle vector");
      reti_pulse();
      expect_take(1, "R3");
      req_q[1] = 1'b1;
      settle("R3");
      reti_pulse();
      cyc(1);

      // R2: masking
      glob_q = 1'b0;
      req_q  = 2'b11;
      settle("R2 global off");
      glob_q = 1'b1; en_q = 2'b00;
      settle("R2 sources off");
      expect_take(1, "R2");
      en_q = 2'b10;
      settle("R2 source 1 on");
      en_q = 2'b11;
      settle("R2 blocked by low handler");
      expect_take(0, "R2");
      reti_pulse();
      settle("R2 source 0 on");
      reti_pulse();
      cyc(1);

      // R6: equal low priority
      hi_q = 2'b00;
      expect_take(0, "R6");
      req_q = 2'b11;
      settle("R6 low tie");
      expect_take(1, "R6");
      reti_pulse();
      settle("R6 second");
      reti_pulse();
      cyc(1);

      // R6 / R8: equal high priority
      hi_q = 2'b11;
      expect_take(0, "R6");
      req_q = 2'b11;
      settle("R8 high blocks high");
      expect_take(1, "R8");
      reti_pulse();
      settle("R8 after return");
      reti_pulse();
      cyc(1);

      // R5: high source 1 beats low source 0
      hi_q = 2'b10;
      expect_take(1, "R5");
      req_q = 2'b11;
      settle("R5 high first");
      expect_take(0, "R5");
      reti_pulse();
      settle("R5 low after");
      reti_pulse();
      cyc(1);

      // R7 / R8 / R9: nesting and returns
      expect_take(0, "R7");
      req_q[0] = 1'b1;
      settle("R7 low in");
      expect_take(1, "R7");
      req_q[1] = 1'b1;
      settle("R7 high nests");
      req_q[0] = 1'b1;
      settle("R8 both levels busy");
      reti_pulse();
      settle("R9 first return keeps low busy");
      expect_take(0, "R9");
      reti_pulse();
      settle("R9 second return");
      reti_pulse();
      cyc(1);

      // R7: low does not nest over low
      hi_q = 2'b00;
      expect_take(0, "R7");
      req_q[0] = 1'b1;
      settle("R7 low in");
      req_q[1] = 1'b1;
      settle("R7 low not nested");
      expect_take(1, "R7");
      reti_pulse();
      settle("R7 low after return");
      reti_pulse();
      cyc(1);

      // R10: stray return
      reti_pulse();
      cyc(1);
      check_idle("R10 stray return");
      reti_pulse();
      settle("R10 stray return no take");
      expect_take(0, "R10");
      req_q[0] = 1'b1;
      settle("R10 later take");
      reti_pulse();
      cyc(1);

      // R11: request held after its clear
      auto_clr = 1'b0;
      expect_take(0, "R11");
      req_q[0] = 1'b1;
      settle("R11 held not retaken");
      expect_take(0, "R11");
      reti_pulse();
      settle("R11 retaken after return");
      req_q[0] = 1'b0;
      reti_pulse();
      settle("R11 released");
      auto_clr = 1'b1;
      check_idle("R4 idle after run");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule